// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. Software sets each pin's direction, drives output levels and samples input levels through a 32-bit register interface with a one-cycle read latency. Each input level passes through a two-flop synchronizer before it reaches the read path or the interrupt logic.

Every pin has its own trigger detector. Three mode registers select level or edge detection, the active polarity, and an override that fires on either transition. Detected events latch into a sticky pending register. Software clears pending bits by writing ones to a separate clear register. An enable mask chooses which pending bits drive one combined, registered interrupt output. A read-only version word reports that both-edge detection is present.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Register word indices (byte offset / 4) are: 0 value, 1 direction, 2 interrupt enable, 3 raw status, 4 pending, 5 clear, 6 edge select, 7 polarity, 8 version, 9 both-edge select. After reset, direction and polarity read all ones for the implemented pins. Enable, pending, edge select and both-edge select read zero.
- R2: A direction bit of 1 makes that pin an input and a 0 makes it an output. `pin_oe` is high exactly for output pins. `pin_out` carries the value register.
- R3: A value read returns, for input pins, the pin level seen through a two-flop synchronizer. For output pins it returns the driven value.
- R4: In level mode (edge select bit 0), polarity 1 triggers while the synchronized pin is high and polarity 0 while it is low. The raw status register shows each pin's trigger condition before any masking.
- R5: In edge mode (edge select bit 1) with the both-edge bit 0, polarity 1 triggers once on a rising transition and polarity 0 once on a falling transition. The opposite transition and a steady level do not trigger.
- R6: In edge mode with the both-edge bit 1, either transition triggers and the polarity bit is ignored.
- R7: A pending bit sets when its trigger condition holds and stays set until a 1 is written to that bit of the clear register. Zero bits of a clear write leave pending unchanged. When a set and a clear meet in the same cycle, the set wins.
- R8: `irq` is the OR over all pins of pending AND enable. It is registered, so it changes one cycle after the pending or enable register changes. With the enable register at zero, `irq` stays low.
- R9: The version register reads the VERSION parameter (at least 3). Writes to the status, pending and version words change nothing.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe. Unmapped word indices and bits above the pin count read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pin_in | input | NPINS | Asynchronous pin levels from the pads |
| pin_out | output | NPINS | Driven levels |
| pin_oe | output | NPINS | Output enable per pin, 1 = driving |
| irq | output | 1 | Combined interrupt request |

## Verification
The trigger logic is exercised on separate pins in each mode: level-high, level-low, rising, falling and both-edge. For each mode the bench applies both the transition that should fire and the one that should not, so a swapped polarity or a missing edge qualifier shows up as a wrong pending bit. Holding a level-mode pin active while clearing it shows that the set wins over the clear. Clearing a held edge-mode pin shows that edges do not retrigger. A mixed input and output pattern on the value register separates the synchronized input path from the driven path. The interrupt output is sampled in the cycle before and the cycle after an enable write, which pins down its one-cycle registered delay.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned BUS_W = 32;

    typedef enum logic [3:0] {
        IDX_VALUE = 4'd0,
        IDX_DIR   = 4'd1,
        IDX_IEN   = 4'd2,
        IDX_STAT  = 4'd3,
        IDX_PEND  = 4'd4,
        IDX_CLR   = 4'd5,
        IDX_EDGE  = 4'd6,
        IDX_POL   = 4'd7,
        IDX_VER   = 4'd8,
        IDX_BOTH  = 4'd9
    } reg_idx_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_cur,
    output logic [W-1:0] sync_prev
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw_in;
        s_d.cur  = s_q.meta;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_cur  = s_q.cur;
    assign sync_prev = s_q.prev;

endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cur,
    input  logic prev,
    input  logic edge_sel,
    input  logic pol,
    input  logic both,
    output logic hit
);

    logic rise, fall, lvl_hit, edg_hit;

    always_comb begin
        rise    = cur & ~prev;
        fall    = ~cur & prev;
        lvl_hit = pol ? cur : ~cur;
        if (both) edg_hit = rise | fall;
        else      edg_hit = pol ? rise : fall;
        hit     = edge_sel ? edg_hit : lvl_hit;
    end

    // R5: an edge-mode trigger only ever coincides with a change of the pin
    a_r5_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel && hit) |-> (cur != prev));

    // R6: with both-edge set, any change fires regardless of polarity
    a_r6_both_any_change: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel && both && (cur != prev)) |-> hit);

    // R4: level mode fires exactly when the pin matches polarity
    a_r4_level_match: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_sel) |-> (hit == (cur == pol)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS   = 32,
    parameter int unsigned VERSION = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);

    localparam logic [BUS_W-1:0] VER_WORD = BUS_W'(VERSION);

    typedef struct packed {
        logic [NPINS-1:0] drv;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] pend;
        logic [NPINS-1:0] edge_sel;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] both;
        logic             irq;
        logic [BUS_W-1:0] rdata;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic [NPINS-1:0] sync_cur, sync_prev, hit;
    logic             wr_stb, rd_stb, clr_wr;
    reg_idx_e         idx;

    gpio_pin_sync #(.W(NPINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (pin_in),
        .sync_cur  (sync_cur),
        .sync_prev (sync_prev)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_trig
        gpio_trig_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur      (sync_cur[p]),
            .prev     (sync_prev[p]),
            .edge_sel (r_q.edge_sel[p]),
            .pol      (r_q.pol[p]),
            .both     (r_q.both[p]),
            .hit      (hit[p])
        );
    end

    function automatic logic [BUS_W-1:0] widen(input logic [NPINS-1:0] v);
        logic [BUS_W-1:0] w;
        w = '0;
        w[NPINS-1:0] = v;
        return w;
    endfunction

    always_comb begin
        idx    = reg_idx_e'(bus_addr);
        wr_stb = bus_en && bus_we;
        rd_stb = bus_en && !bus_we;
        clr_wr = wr_stb && (idx == IDX_CLR);
    end

    always_comb begin
        r_d = r_q;

        if (wr_stb) begin
            case (idx)
                IDX_VALUE: r_d.drv      = bus_wdata[NPINS-1:0];
                IDX_DIR:   r_d.dir      = bus_wdata[NPINS-1:0];
                IDX_IEN:   r_d.ien      = bus_wdata[NPINS-1:0];
                IDX_EDGE:  r_d.edge_sel = bus_wdata[NPINS-1:0];
                IDX_POL:   r_d.pol      = bus_wdata[NPINS-1:0];
                IDX_BOTH:  r_d.both     = bus_wdata[NPINS-1:0];
                default:   ;
            endcase
        end

        // clear first, then set: a same-cycle trigger wins
        if (clr_wr) r_d.pend = r_q.pend & ~bus_wdata[NPINS-1:0];
        r_d.pend = r_d.pend | hit;

        r_d.irq = |(r_q.pend & r_q.ien);

        if (rd_stb) begin
            case (idx)
                IDX_VALUE: r_d.rdata = widen((r_q.dir & sync_cur) | (~r_q.dir & r_q.drv));
                IDX_DIR:   r_d.rdata = widen(r_q.dir);
                IDX_IEN:   r_d.rdata = widen(r_q.ien);
                IDX_STAT:  r_d.rdata = widen(hit);
                IDX_PEND:  r_d.rdata = widen(r_q.pend);
                IDX_EDGE:  r_d.rdata = widen(r_q.edge_sel);
                IDX_POL:   r_d.rdata = widen(r_q.pol);
                IDX_VER:   r_d.rdata = VER_WORD;
                IDX_BOTH:  r_d.rdata = widen(r_q.both);
                default:   r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.dir      <= '1;
            r_q.pol      <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;
    assign pin_out   = r_q.drv;
    assign pin_oe    = ~r_q.dir;
    assign irq       = r_q.irq;

    // R8: an enabled pending bit raises irq on the next cycle
    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(r_q.pend & r_q.ien)) |=> irq);

    // R8: without an enabled pending bit irq is low on the next cycle
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(r_q.pend & r_q.ien)) |=> !irq);

    // R7: pending bits only drop through a clear write
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((r_q.pend & $past(r_q.pend)) == $past(r_q.pend)));

    // R4, R7: every trigger is latched into pending on the next edge
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((r_q.pend & $past(hit)) == $past(hit)));

    // R9: version reads report both-edge support
    a_r9_version: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && idx == IDX_VER) |=> (bus_rdata >= 32'd3));

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

    localparam int unsigned NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] exp_q[$];
    string       req_q[$];
    logic        rd_fire = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_irq_ctrl #(.NPINS(NP), .VERSION(3)) i_gpio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R10: the read result is due one cycle after the strobe
    always @(posedge clk) rd_fire <= bus_en && !bus_we;

    // scoreboard monitor
    always @(negedge clk) begin
        if (rd_fire) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected read", bus_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string       r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(bus_rdata === e, r, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        req_q.push_back(req);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq === 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
        check(pin_oe === '0, "R1 oe after reset", pin_oe, 32'h0);
        rd(4'd1, 32'hFFFF_FFFF, "R1 direction reset");
        rd(4'd7, 32'hFFFF_FFFF, "R1 polarity reset");
        rd(4'd2, 32'h0, "R1 enable reset");
        rd(4'd4, 32'h0, "R1 pending reset");
        rd(4'd6, 32'h0, "R1 edge reset");
        rd(4'd9, 32'h0, "R1 both reset");
        rd(4'd8, 32'd3, "R9 version");
        rd(4'd10, 32'h0, "R10 unmapped");

        // R2 / R3 direction and value
        wr(4'd1, 32'hFFFF_0000);
        wr(4'd0, 32'h0000_A5A5);
        check(pin_oe === 32'h0000_FFFF, "R2 output enable", pin_oe, 32'h0000_FFFF);
        check(pin_out === 32'h0000_A5A5, "R2 driven value", pin_out, 32'h0000_A5A5);
        pin_in = 32'h1234_FFFF;
        settle();
        rd(4'd0, 32'h1234_A5A5, "R3 mixed value read");
        rd(4'd3, 32'h1234_FFFF, "R4 raw status level-high");
        rd(4'd4, 32'h1234_FFFF, "R4 pending level-high");
        check(irq === 1'b0, "R8 masked by zero enable", {31'b0, irq}, 32'h0);
        pin_in = '0;
        settle();
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd4, 32'h0, "R7 clear all");
        rd(4'd3, 32'h0, "R4 status idle");

        // R4 level-high on pin 17, R8 timing, R7 set wins
        pin_in = 32'h1 << 17;
        settle();
        rd(4'd3, 32'h1 << 17, "R4 status pin17");
        rd(4'd4, 32'h1 << 17, "R4 pending pin17");
        wr(4'd2, 32'h1 << 17);
        check(irq === 1'b0, "R8 irq one cycle late", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check(irq === 1'b1, "R8 irq asserted", {31'b0, irq}, 32'h1);
        wr(4'd5, 32'h1 << 17);
        rd(4'd4, 32'h1 << 17, "R7 set wins over clear");
        pin_in = '0;
        settle();
        wr(4'd5, 32'h1 << 17);
        rd(4'd4, 32'h0, "R7 cleared pin17");
        check(irq === 1'b0, "R8 irq dropped", {31'b0, irq}, 32'h0);

        // R4 level-low on pin 18
        wr(4'd7, ~(32'h1 << 18));
        rd(4'd4, 32'h1 << 18, "R4 level-low pending");
        pin_in = 32'h1 << 18;
        settle();
        wr(4'd5, 32'h1 << 18);
        rd(4'd4, 32'h0, "R4 level-low released");

        // R5 rising on pin 19
        wr(4'd6, 32'h1 << 19);
        pin_in = pin_in | (32'h1 << 19);
        settle();
        rd(4'd4, 32'h1 << 19, "R5 rising pending");
        wr(4'd5, 32'h1 << 19);
        rd(4'd4, 32'h0, "R5 held high no retrigger");
        pin_in = pin_in & ~(32'h1 << 19);
        settle();
        rd(4'd4, 32'h0, "R5 falling ignored in rising mode");

        // R5 falling on pin 21
        wr(4'd6, (32'h1 << 19) | (32'h1 << 21));
        wr(4'd7, ~((32'h1 << 18) | (32'h1 << 21)));
        pin_in = pin_in | (32'h1 << 21);
        settle();
        rd(4'd4, 32'h0, "R5 rising ignored in falling mode");
        pin_in = pin_in & ~(32'h1 << 21);
        settle();
        rd(4'd4, 32'h1 << 21, "R5 falling pending");
        wr(4'd5, 32'h1 << 21);

        // R6 both edges on pin 22, polarity 0 ignored
        wr(4'd6, (32'h1 << 19) | (32'h1 << 21) | (32'h1 << 22));
        wr(4'd9, 32'h1 << 22);
        wr(4'd7, ~((32'h1 << 18) | (32'h1 << 21) | (32'h1 << 22)));
        rd(4'd4, 32'h0, "R6 quiet before edges");
        pin_in = pin_in | (32'h1 << 22);
        settle();
        rd(4'd4, 32'h1 << 22, "R6 rising with polarity 0");
        wr(4'd5, 32'h1 << 22);
        rd(4'd4, 32'h0, "R6 cleared");
        pin_in = pin_in & ~(32'h1 << 22);
        settle();
        rd(4'd4, 32'h1 << 22, "R6 falling");

        // R7 zero clear, R9 read-only words
        wr(4'd5, 32'h0);
        rd(4'd4, 32'h1 << 22, "R7 zero bits keep pending");
        wr(4'd4, 32'h0);
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd8, 32'h0);
        rd(4'd4, 32'h1 << 22, "R9 pending write ignored");
        rd(4'd8, 32'd3, "R9 version write ignored");
        wr(4'd5, 32'h1 << 22);
        rd(4'd4, 32'h0, "R7 final clear");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 32'h0);
        finish_run();
    end

endmodule